// File: doc/BRIEF.md
# Priority Interrupt Controller

This block collects 64 level-sensitive interrupt sources behind a 64-bit register interface. Each source has an enable bit and a 4-bit priority. When any source is raised, enabled and given a non-zero priority, the block asserts one request line. It also presents the priority level of the winning source and an event code for that source. Software changes enables and control bits only through separate set and clear write ports. A write therefore touches only the bits written as 1, and no read-modify-write is needed.

The source inputs are registered once per clock, and the request outputs are derived from that registered copy. Register writes take effect at the clock edge that accepts them. Reads are combinational from the read address. The register port is a plain one-cycle strobe with no back-pressure: the block accepts a write in every cycle that `wr_en` is high, and a read never stalls.

Top module: `pic_core`

## Requirements
- R1: After reset, all enables are 0, all priority fields are 0 and the control register is 0. `irq_req`, `irq_level`, `irq_code` and `line_mode` are all 0.
- R2: Writing the enable port at byte address 0x70 sets enable n for every bit n of `wr_data[31:0]` that is 1, covering sources 0 to 31. The port at 0x78 does the same for source 32+n. Zero bits leave their enables unchanged. Reading either address returns the current enables of that half in bits [31:0].
- R3: Writing the disable port at 0x80 clears enable n for each 1 bit n, covering sources 0 to 31. The port at 0x88 does the same for sources 32 to 63. Zero bits change nothing. Once a source's enable is cleared, that source no longer contributes to the request.
- R4: There are eight priority registers at 0x10 + 8*k, for k = 0 to 7, each holding `wr_data[31:0]`. Source i takes its priority from register i/8, bits [(i%8)*4 +: 4]. Reading a priority register returns its 32 bits, and the upper half of the read word is 0.
- R5: A source whose priority is 0 never causes a request, even when it is raised and enabled.
- R6: The control register is 32 bits wide. A write at 0x00 ORs the written bits in. A write at 0x08 clears each bit written as 1. Both addresses read the register back. Bit 0 drives `line_mode`.
- R7: Suppose a source has a defined code, a non-zero priority and its enable set. If its input is high before clock edge k, then `irq_req` is high after edge k. When the input drops, `irq_req` falls one edge later.
- R8: Among the requesting sources, the highest priority wins. On equal priorities, the lowest source index wins. `irq_level` shows the winner's priority.
- R9: `irq_code` is the winner's ordinal times 0x20. The ordinals are as follows:
  - sources 0 to 3 use 0x12 + 3*i;
  - sources 4 to 7 use 0x40 + (i-4);
  - sources 12 to 17 use 0x50 + (i-12);
  - sources 18 to 22 use 0x32 + (i-18);
  - sources 32 to 38 use 0x20 + (i-32);
  - sources 39 to 42 use 0x38 + (i-39);
  - source 63 uses 0x2B.

  `irq_code` and `irq_level` are 0 while there is no request.
- R10: A source without a defined ordinal never requests, whatever its priority and enable.
- R11: Reads at 0x50 and 0x58 return the registered raw input levels for sources 0 to 31 and 32 to 63. Reads at 0x60 and 0x68 return the registered levels ANDed with the enables. Writes to these four addresses, and to unmapped addresses, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 8 | Write byte address (bits [2:0] ignored) |
| wr_data | input | 64 | Write data |
| rd_addr | input | 8 | Read byte address (bits [2:0] ignored) |
| rd_data | output | 64 | Combinational read data |
| src_lvl | input | 64 | Level interrupt inputs, bit n is source n |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 4 | Priority of the winning source |
| irq_code | output | 12 | Event code of the winning source |
| line_mode | output | 1 | Control bit 0, external line mode |

## Verification
A corrupted enable bit appears on the read port at the first read after the faulty write. It also shows in the request outputs one edge after the affected source is raised. A wrong priority nibble or tie rule appears as a wrong `irq_level` or `irq_code` as soon as two sources with chosen priorities are raised together. A wrong ordinal entry appears on `irq_code` in the cycle after its source alone is raised. For undefined sources, the same stimulus shows up as a spurious request.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int N_SRC       = 64;
  localparam int HALF_W      = 32;
  localparam int PRIO_W      = 4;
  localparam int PER_REG     = 8;
  localparam int N_PRIO_REGS = N_SRC / PER_REG;
  localparam int ORD_W       = 7;
  localparam int CODE_W      = ORD_W + 5;
  localparam int IDX_W       = $clog2(N_SRC);
  localparam int DATA_W      = 64;
  localparam int ADDR_W      = 8;
  localparam int WIDX_W      = ADDR_W - 3;

  // word indices (byte address / 8)
  localparam int W_CSET  = 0;
  localparam int W_CCLR  = 1;
  localparam int W_PRIO0 = 2;
  localparam int W_RAW0  = 10;
  localparam int W_RAW1  = 11;
  localparam int W_PEND0 = 12;
  localparam int W_PEND1 = 13;
  localparam int W_ENA0  = 14;
  localparam int W_ENA1  = 15;
  localparam int W_DIS0  = 16;
  localparam int W_DIS1  = 17;

  // returns {defined, ordinal}
  function automatic logic [ORD_W:0] src_ordinal(input int i);
    logic [ORD_W:0] r;
    r = '0;
    if (i >= 0 && i <= 3)        r = {1'b1, ORD_W'(8'h12 + 3 * i)};
    else if (i >= 4 && i <= 7)   r = {1'b1, ORD_W'(8'h40 + i - 4)};
    else if (i >= 12 && i <= 17) r = {1'b1, ORD_W'(8'h50 + i - 12)};
    else if (i >= 18 && i <= 22) r = {1'b1, ORD_W'(8'h32 + i - 18)};
    else if (i >= 32 && i <= 38) r = {1'b1, ORD_W'(8'h20 + i - 32)};
    else if (i >= 39 && i <= 42) r = {1'b1, ORD_W'(8'h38 + i - 39)};
    else if (i == 63)            r = {1'b1, ORD_W'(8'h2B)};
    return r;
  endfunction
endpackage

// File: rtl/pic_sampler.sv
module pic_sampler #(
  parameter int N = pic_pkg::N_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_lvl,
  output logic [N-1:0] raw_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= src_lvl;
  end
endmodule

// File: rtl/pic_regfile.sv
module pic_regfile
  import pic_pkg::*;
#(
  parameter int N  = N_SRC,
  parameter int HW = HALF_W,
  parameter int PW = PRIO_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  localparam int NPR = N / PER_REG,
  localparam int WIW = AW - 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  input  logic [N-1:0]    raw_q,
  output logic [N-1:0]    en_q,
  output logic [N*PW-1:0] prio_flat,
  output logic [HW-1:0]   ctrl_q
);
  logic [WIW-1:0] wr_idx, rd_idx;
  logic [HW-1:0]  wlo;
  logic [HW-1:0]  prio_reg [NPR];
  logic [N-1:0]   pend;
  logic           unused_bits;

  assign wr_idx = wr_addr[AW-1:3];
  assign rd_idx = rd_addr[AW-1:3];
  assign wlo    = wr_data[HW-1:0];
  assign pend   = raw_q & en_q;
  assign unused_bits = ^{wr_data[DW-1:HW], wr_addr[2:0], rd_addr[2:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      en_q   <= '0;
      for (int k = 0; k < NPR; k++) prio_reg[k] <= '0;
    end else if (wr_en) begin
      case (wr_idx)
        WIW'(W_CSET): ctrl_q        <= ctrl_q | wlo;
        WIW'(W_CCLR): ctrl_q        <= ctrl_q & ~wlo;
        WIW'(W_ENA0): en_q[HW-1:0]  <= en_q[HW-1:0] | wlo;
        WIW'(W_ENA1): en_q[N-1:HW]  <= en_q[N-1:HW] | wlo;
        WIW'(W_DIS0): en_q[HW-1:0]  <= en_q[HW-1:0] & ~wlo;
        WIW'(W_DIS1): en_q[N-1:HW]  <= en_q[N-1:HW] & ~wlo;
        default: begin
          for (int k = 0; k < NPR; k++)
            if (wr_idx == WIW'(W_PRIO0 + k)) prio_reg[k] <= wlo;
        end
      endcase
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_unpack
    assign prio_flat[g*PW +: PW] = prio_reg[g / PER_REG][(g % PER_REG) * PW +: PW];
  end

  always_comb begin
    rd_data = '0;
    case (rd_idx)
      WIW'(W_CSET), WIW'(W_CCLR): rd_data[HW-1:0] = ctrl_q;
      WIW'(W_RAW0):               rd_data[HW-1:0] = raw_q[HW-1:0];
      WIW'(W_RAW1):               rd_data[HW-1:0] = raw_q[N-1:HW];
      WIW'(W_PEND0):              rd_data[HW-1:0] = pend[HW-1:0];
      WIW'(W_PEND1):              rd_data[HW-1:0] = pend[N-1:HW];
      WIW'(W_ENA0), WIW'(W_DIS0): rd_data[HW-1:0] = en_q[HW-1:0];
      WIW'(W_ENA1), WIW'(W_DIS1): rd_data[HW-1:0] = en_q[N-1:HW];
      default: begin
        for (int k = 0; k < NPR; k++)
          if (rd_idx == WIW'(W_PRIO0 + k)) rd_data[HW-1:0] = prio_reg[k];
      end
    endcase
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int N  = pic_pkg::N_SRC,
  parameter int PW = pic_pkg::PRIO_W,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]    act,
  input  logic [N*PW-1:0] prio_flat,
  output logic            any,
  output logic [PW-1:0]   lvl,
  output logic [IW-1:0]   idx
);
  // scanning downward with >= lets the lowest index win a tie
  always_comb begin
    any = 1'b0;
    lvl = '0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act[i] && prio_flat[i*PW +: PW] >= lvl) begin
        any = 1'b1;
        lvl = prio_flat[i*PW +: PW];
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_encoder.sv
module pic_encoder
  import pic_pkg::*;
#(
  parameter int N  = N_SRC,
  parameter int OW = ORD_W,
  localparam int IW = $clog2(N),
  localparam int CW = OW + 5
) (
  input  logic          any,
  input  logic [IW-1:0] idx,
  output logic [N-1:0]  ord_ok,
  output logic [CW-1:0] code
);
  logic [CW-1:0] code_tab [N];

  for (genvar g = 0; g < N; g++) begin : g_tab
    localparam logic [OW:0] ENT = src_ordinal(g);
    assign ord_ok[g]   = ENT[OW];
    assign code_tab[g] = ENT[OW] ? {ENT[OW-1:0], 5'b0} : '0;
  end

  assign code = any ? code_tab[idx] : '0;
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [N_SRC-1:0]    src_lvl,
  output logic                irq_req,
  output logic [PRIO_W-1:0]   irq_level,
  output logic [CODE_W-1:0]   irq_code,
  output logic                line_mode
);
  logic [N_SRC-1:0]        raw_q, en_q, ord_ok, prio_nz, act;
  logic [N_SRC*PRIO_W-1:0] prio_flat;
  logic [HALF_W-1:0]       ctrl_q;
  logic [IDX_W-1:0]        win_idx;
  logic                    unused_ctrl;

  pic_sampler #(.N(N_SRC)) u_samp (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .raw_q(raw_q)
  );

  pic_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .raw_q(raw_q), .en_q(en_q), .prio_flat(prio_flat), .ctrl_q(ctrl_q)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_nz
    assign prio_nz[g] = |prio_flat[g*PRIO_W +: PRIO_W];
  end

  assign act = raw_q & en_q & prio_nz & ord_ok;

  pic_arbiter #(.N(N_SRC), .PW(PRIO_W)) u_arb (
    .act(act), .prio_flat(prio_flat), .any(irq_req),
    .lvl(irq_level), .idx(win_idx)
  );

  pic_encoder #(.N(N_SRC), .OW(ORD_W)) u_enc (
    .any(irq_req), .idx(win_idx), .ord_ok(ord_ok), .code(irq_code)
  );

  assign line_mode   = ctrl_q[0];
  assign unused_ctrl = ^ctrl_q[HALF_W-1:1];
endmodule

// File: rtl/pic_core_chk.sv
module pic_core_chk
  import pic_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              irq_req,
  input logic [PRIO_W-1:0] irq_level,
  input logic [CODE_W-1:0] irq_code,
  input logic              line_mode,
  input logic [N_SRC-1:0]  en_q
);
  logic [WIDX_W-1:0] widx;
  assign widx = wr_addr[ADDR_W-1:3];

  // R2
  ena_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == WIDX_W'(W_ENA0)) |=>
      ((en_q[HALF_W-1:0] & $past(wr_data[HALF_W-1:0])) == $past(wr_data[HALF_W-1:0])));

  // R3
  dis_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == WIDX_W'(W_DIS1)) |=>
      ((en_q[N_SRC-1:HALF_W] & $past(wr_data[HALF_W-1:0])) == '0));

  // R6
  mode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == WIDX_W'(W_CSET) && wr_data[0]) |=> line_mode);

  // R6
  mode_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == WIDX_W'(W_CCLR) && wr_data[0]) |=> !line_mode);

  // R5
  req_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_level != '0));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_level == '0 && irq_code == '0));

  // R10
  code_defined_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_code != '0 && irq_code[4:0] == '0));
endmodule

bind pic_core pic_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .irq_req(irq_req), .irq_level(irq_level),
  .irq_code(irq_code), .line_mode(line_mode), .en_q(en_q)
);

// File: tb/pic_core_test.sv
`timescale 1ns/1ps
module pic_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [63:0] rd_data;
  logic [63:0] src_lvl = '0;
  logic        irq_req;
  logic [3:0]  irq_level;
  logic [11:0] irq_code;
  logic        line_mode;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pic_core uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .src_lvl(src_lvl), .irq_req(irq_req), .irq_level(irq_level),
    .irq_code(irq_code), .line_mode(line_mode)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; src_lvl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic drive(input logic [63:0] s);
    @(negedge clk);
    src_lvl = s;
    @(negedge clk);
  endtask

  task automatic chk_irq(input string req, input logic r,
                         input logic [3:0] l, input logic [11:0] c);
    check(req, "irq_req", 64'(irq_req), 64'(r));
    check(req, "irq_level", 64'(irq_level), 64'(l));
    check(req, "irq_code", 64'(irq_code), 64'(c));
  endtask

  task automatic t_reset();
    logic [63:0] d;
    do_reset();
    rd(8'h00, d); check("R1", "ctrl", d, 0);
    rd(8'h70, d); check("R1", "ena lo", d, 0);
    rd(8'h78, d); check("R1", "ena hi", d, 0);
    rd(8'h10, d); check("R1", "prio0", d, 0);
    rd(8'h48, d); check("R1", "prio7", d, 0);
    chk_irq("R1", 0, 0, 0);
    check("R1", "line_mode", 64'(line_mode), 0);
  endtask

  task automatic t_enable();
    logic [63:0] d;
    do_reset();
    wr(8'h70, 64'h5);
    rd(8'h70, d); check("R2", "ena lo first", d, 64'h5);
    wr(8'h70, 64'h2);
    rd(8'h70, d); check("R2", "ena lo zeros keep", d, 64'h7);
    wr(8'h78, 64'h8000_0001);
    rd(8'h78, d); check("R2", "ena hi", d, 64'h8000_0001);
    rd(8'h70, d); check("R2", "ena lo untouched", d, 64'h7);
  endtask

  task automatic t_disable();
    logic [63:0] d;
    do_reset();
    wr(8'h70, 64'hF);
    wr(8'h80, 64'h4);
    rd(8'h70, d); check("R3", "dis lo", d, 64'hB);
    wr(8'h80, 64'h0);
    rd(8'h80, d); check("R3", "dis zeros keep", d, 64'hB);
    wr(8'h78, 64'h3);
    wr(8'h88, 64'h1);
    rd(8'h78, d); check("R3", "dis hi", d, 64'h2);
    rd(8'h70, d); check("R3", "lo untouched", d, 64'hB);
  endtask

  task automatic t_prio();
    logic [63:0] d;
    do_reset();
    wr(8'h10, 64'hFFFF_FFFF_8765_4321);
    rd(8'h10, d); check("R4", "prio0 readback", d, 64'h8765_4321);
    wr(8'h70, 64'h8);
    drive(64'h8);
    chk_irq("R4", 1, 4'h4, 12'h360);
  endtask

  task automatic t_zero_prio();
    logic [63:0] d;
    do_reset();
    wr(8'h70, 64'h1);
    drive(64'h1);
    chk_irq("R5", 0, 0, 0);
    rd(8'h60, d); check("R11", "pend lo", d, 64'h1);
  endtask

  task automatic t_request();
    do_reset();
    wr(8'h10, 64'h30);
    wr(8'h70, 64'h2);
    drive(64'h2);
    chk_irq("R7", 1, 4'h3, 12'h2A0);
    drive(64'h0);
    chk_irq("R7", 0, 0, 0);
    drive(64'h2);
    wr(8'h80, 64'h2);
    chk_irq("R3", 0, 0, 0);
  endtask

  task automatic t_arb();
    do_reset();
    wr(8'h10, 64'h0055_0000);
    wr(8'h18, 64'h0007_0000);
    wr(8'h70, 64'h1030);
    drive(64'h30);
    chk_irq("R8", 1, 4'h5, 12'h800);
    drive(64'h1030);
    chk_irq("R8", 1, 4'h7, 12'hA00);
    drive(64'h20);
    chk_irq("R9", 1, 4'h5, 12'h820);
  endtask

  task automatic t_undef();
    do_reset();
    wr(8'h18, 64'hF);
    wr(8'h30, 64'h3000_0002);
    wr(8'h48, 64'h1000_0000);
    wr(8'h70, 64'h100);
    wr(8'h78, 64'h8000_0081);
    drive(64'h100);
    chk_irq("R10", 0, 0, 0);
    drive(64'h1_0000_0100);
    chk_irq("R10", 1, 4'h2, 12'h400);
    drive(64'h81_0000_0100);
    chk_irq("R9", 1, 4'h3, 12'h700);
    drive(64'h8000_0000_0000_0000);
    chk_irq("R9", 1, 4'h1, 12'h560);
  endtask

  task automatic t_status();
    logic [63:0] d;
    do_reset();
    wr(8'h70, 64'h30);
    wr(8'h78, 64'hFFFF);
    drive(64'hDEAD_BEEF_0000_00F0);
    rd(8'h50, d); check("R11", "raw lo", d, 64'hF0);
    rd(8'h58, d); check("R11", "raw hi", d, 64'hDEAD_BEEF);
    rd(8'h60, d); check("R11", "pend lo", d, 64'h30);
    rd(8'h68, d); check("R11", "pend hi", d, 64'hBEEF);
    wr(8'h60, '1);
    wr(8'hF8, '1);
    rd(8'h60, d); check("R11", "pend after write", d, 64'h30);
    rd(8'h70, d); check("R11", "ena after write", d, 64'h30);
    rd(8'h00, d); check("R11", "ctrl after unmapped", d, 64'h0);
  endtask

  task automatic t_ctrl();
    logic [63:0] d;
    do_reset();
    wr(8'h00, 64'h11);
    check("R6", "mode set", 64'(line_mode), 1);
    rd(8'h00, d); check("R6", "ctrl at set", d, 64'h11);
    rd(8'h08, d); check("R6", "ctrl at clr", d, 64'h11);
    wr(8'h08, 64'h10);
    rd(8'h00, d); check("R6", "ctrl partial clr", d, 64'h1);
    wr(8'h08, 64'h0);
    check("R6", "zero clr keeps", 64'(line_mode), 1);
    wr(8'h08, 64'h1);
    check("R6", "mode clr", 64'(line_mode), 0);
  endtask

  initial begin
    t_reset();
    t_enable();
    t_disable();
    t_prio();
    t_zero_prio();
    t_request();
    t_arb();
    t_undef();
    t_status();
    t_ctrl();
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule